// File: doc/BRIEF.md
# Scatter-Gather Bus-Master DMA Engine

This block moves a disk transfer between a word-wide device stream and system memory without processor help. Software writes a table of 16-byte descriptors into memory, each naming a buffer address and a byte length, with a flag on the final entry. It then loads the table base and the address of a completion area into a small 32-bit register file, picks a direction and sets a start bit. The engine fetches each descriptor, streams the buffer to or from the device side, and moves on until the flagged entry is done.

Once the last data word has been accepted by memory, the engine fills the completion area with all-ones words. Software polls that area to confirm the data is visible before it trusts the buffers. Separate byte counters for the device side and the memory side stay readable after the engine halts, whether it completed, faulted or was stopped. A two-bit interrupt status (done, bus fault) with its own enable drives a single interrupt line.

Top module: `sgdma_top`

## Requirements
- R1: After reset every register reads zero, the interrupt line is low and no memory request or device handshake is pending.
- R2: Register word indices are: 0 timing scratch, 1 table base, 2 table base upper half, 3 current buffer address, 4 reads zero, 5 device byte count, 6 memory byte count, 7 control, 8 completion area address, 9 interrupt status, 10 interrupt enable. Control bits are 0 start, 1 stop, 2 direction, 3 busy (read-only) and 4 fault (read-only). A descriptor is four big-endian words read in ascending order: word 1 is the buffer address, and word 3 holds the last-entry flag in bit 31 and the byte length in bits 15:0. Words 0 and 2 are ignored.
- R3: With direction 1, device words are written to memory at ascending word addresses from each buffer address. With direction 0, memory words are read from there and presented to the device in the same order.
- R4: Descriptors are taken 16 bytes apart until the entry with the last flag has been served. A zero-length entry moves no data.
- R5: After the final data write, the engine writes 32 all-ones words (128 bytes) from the completion address upward, then sets interrupt status bit 0. It never writes beyond that area.
- R6: Both byte counters clear on start. Each word adds min(4, bytes left in the entry) on its side. The counters keep their values after completion, fault or stop.
- R7: Writing control bit 1 requests a halt. The bit reads 1 until the engine is idle and then clears by itself. A halted transfer writes no completion area and raises no done status.
- R8: An error response on any memory access sets the fault bit, clears busy, sets interrupt status bit 1 and skips the completion area. A stop write clears the fault bit.
- R9: A start write while busy or while a stop is pending is ignored, including its direction bit.
- R10: Writing 1 to an interrupt status bit clears it. The interrupt line is the OR of the status bits masked by the enable bits at index 10.
- R11: A memory request holds its address, data and write flag until granted, and device output data holds until taken, unless a stop is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory access is a write |
| mem_addr_o | output | 32 | Memory byte address (word aligned) |
| mem_wdata_o | output | 32 | Memory write data |
| mem_gnt_i | input | 1 | Access performed this cycle |
| mem_err_i | input | 1 | Error response, valid with grant |
| mem_rdata_i | input | 32 | Read data, valid with grant |
| dev_in_valid_i | input | 1 | Device word available |
| dev_in_data_i | input | 32 | Device word toward memory |
| dev_in_ready_o | output | 1 | Engine takes a device word |
| dev_out_valid_o | output | 1 | Word available for the device |
| dev_out_data_o | output | 32 | Word toward the device |
| dev_out_ready_i | input | 1 | Device takes the word |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions watch every cycle for request and device-output stability while a grant is awaited, and for the halt taking effect one cycle after a stop. They also check that a start is only seen by an idle sequencer, that each byte counter trails the other in the order the direction implies, and that the done and fault status bits follow their events. Only the bench scenarios can show that descriptors are decoded with the right byte order and chained correctly across zero-length entries. The same holds for data order through partial final words, the exact extent of the completion area, and the counter values left behind by a stop or a fault.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_XFER, ST_MARK} seq_st_e;

  localparam logic [3:0] RI_TIMING  = 4'd0;
  localparam logic [3:0] RI_TBL_LO  = 4'd1;
  localparam logic [3:0] RI_TBL_HI  = 4'd2;
  localparam logic [3:0] RI_CUR_LO  = 4'd3;
  localparam logic [3:0] RI_CUR_HI  = 4'd4;
  localparam logic [3:0] RI_DEV_CNT = 4'd5;
  localparam logic [3:0] RI_MEM_CNT = 4'd6;
  localparam logic [3:0] RI_CTRL    = 4'd7;
  localparam logic [3:0] RI_DONE_AD = 4'd8;
  localparam logic [3:0] RI_IRQ_ST  = 4'd9;
  localparam logic [3:0] RI_IRQ_EN  = 4'd10;

  function automatic logic [31:0] swap32(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction
endpackage

// File: rtl/sgdma_regs.sv
module sgdma_regs
  import sgdma_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [3:0]       addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  output logic             start_o,
  output logic             stop_o,
  output logic             dir_o,
  output logic [31:0]      tbl_o,
  output logic [31:0]      done_addr_o,
  input  logic             active_i,
  input  logic             done_i,
  input  logic             err_i,
  input  logic [31:0]      cur_addr_i,
  input  logic [CNT_W-1:0] dev_cnt_i,
  input  logic [CNT_W-1:0] mem_cnt_i,
  output logic             irq_o
);
  logic [31:0] timing_q, tbl_lo_q, tbl_hi_q, done_ad_q;
  logic        dir_q, stop_q, fault_q;
  logic [1:0]  ist_q, ien_q, w1c;
  logic        ctrl_wr;

  assign ctrl_wr = we_i && (addr_i == RI_CTRL);
  assign start_o = ctrl_wr && wdata_i[0] && !wdata_i[1] && !active_i && !stop_q;
  assign w1c     = (we_i && addr_i == RI_IRQ_ST) ? wdata_i[1:0] : 2'b00;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      timing_q <= '0; tbl_lo_q <= '0; tbl_hi_q <= '0; done_ad_q <= '0;
      dir_q <= 1'b0; stop_q <= 1'b0; fault_q <= 1'b0;
      ist_q <= '0; ien_q <= '0;
    end else begin
      if (we_i) begin
        case (addr_i)
          RI_TIMING:  timing_q  <= wdata_i;
          RI_TBL_LO:  tbl_lo_q  <= wdata_i;
          RI_TBL_HI:  tbl_hi_q  <= wdata_i;
          RI_DONE_AD: done_ad_q <= wdata_i;
          RI_IRQ_EN:  ien_q     <= wdata_i[1:0];
          default: ;
        endcase
      end
      if (start_o) dir_q <= wdata_i[2];
      if (ctrl_wr && wdata_i[1]) stop_q <= 1'b1;
      else if (stop_q && !active_i) stop_q <= 1'b0;
      if (err_i) fault_q <= 1'b1;
      else if (ctrl_wr && wdata_i[1]) fault_q <= 1'b0;
      ist_q <= (ist_q & ~w1c) | {err_i, done_i};
    end
  end

  always_comb begin
    case (addr_i)
      RI_TIMING:  rdata_o = timing_q;
      RI_TBL_LO:  rdata_o = tbl_lo_q;
      RI_TBL_HI:  rdata_o = tbl_hi_q;
      RI_CUR_LO:  rdata_o = cur_addr_i;
      RI_DEV_CNT: rdata_o = 32'(dev_cnt_i);
      RI_MEM_CNT: rdata_o = 32'(mem_cnt_i);
      RI_CTRL:    rdata_o = {27'd0, fault_q, active_i, dir_q, stop_q, 1'b0};
      RI_DONE_AD: rdata_o = done_ad_q;
      RI_IRQ_ST:  rdata_o = {30'd0, ist_q};
      RI_IRQ_EN:  rdata_o = {30'd0, ien_q};
      default:    rdata_o = '0;
    endcase
  end

  assign stop_o      = stop_q;
  assign dir_o       = dir_q;
  assign tbl_o       = tbl_lo_q;
  assign done_addr_o = done_ad_q;
  assign irq_o       = |(ist_q & ien_q);

  assert_done_status_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> ist_q[0]);
  assert_fault_status_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |=> (ist_q[1] && fault_q));
  assert_stop_selfclear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_q && !active_i && !ctrl_wr) |=> !stop_q);
endmodule

// File: rtl/sgdma_seq.sv
module sgdma_seq
  import sgdma_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int LEN_W      = 16,
  parameter int MARK_BYTES = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             dir_i,
  input  logic [31:0]      tbl_i,
  input  logic [31:0]      done_addr_i,
  output logic             active_o,
  output logic             done_o,
  output logic             err_o,
  output logic [31:0]      cur_addr_o,
  output logic [CNT_W-1:0] dev_cnt_o,
  output logic [CNT_W-1:0] mem_cnt_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [31:0]      mem_addr_o,
  output logic [31:0]      mem_wdata_o,
  input  logic             mem_gnt_i,
  input  logic             mem_err_i,
  input  logic [31:0]      mem_rdata_i,
  input  logic             dev_in_valid_i,
  input  logic [31:0]      dev_in_data_i,
  output logic             dev_in_ready_o,
  output logic             dev_out_valid_o,
  output logic [31:0]      dev_out_data_o,
  input  logic             dev_out_ready_i
);
  localparam int MARK_WORDS = MARK_BYTES / 4;
  localparam int MW_W       = (MARK_WORDS > 1) ? $clog2(MARK_WORDS) : 1;

  seq_st_e          state_q;
  logic [1:0]       widx_q;
  logic [MW_W-1:0]  mark_q;
  logic [31:0]      tbl_q, addr_q, buf_q;
  logic [LEN_W-1:0] rem_q;
  logic             eol_q, have_q;
  logic [CNT_W-1:0] dev_cnt_q, mem_cnt_q;

  logic [31:0]      sw;
  logic [LEN_W-1:0] len_w;
  logic [2:0]       step;
  logic             seg_last, mhs, dhs_in, dhs_out, abort, sw_unused;
  seq_st_e          next_seg;

  assign sw        = swap32(mem_rdata_i);
  assign len_w     = sw[LEN_W-1:0];
  assign sw_unused = ^sw[30:LEN_W];
  assign step      = (rem_q >= LEN_W'(4)) ? 3'd4 : rem_q[2:0];
  assign seg_last  = (rem_q <= LEN_W'(4));
  assign next_seg  = eol_q ? ST_MARK : ST_FETCH;

  assign mem_req_o = (state_q == ST_FETCH) || (state_q == ST_MARK) ||
                     ((state_q == ST_XFER) && (dir_i ? have_q : !have_q));
  assign mem_we_o  = (state_q == ST_MARK) || ((state_q == ST_XFER) && dir_i);
  always_comb begin
    case (state_q)
      ST_FETCH: mem_addr_o = tbl_q + 32'({widx_q, 2'b00});
      ST_MARK:  mem_addr_o = done_addr_i + 32'({mark_q, 2'b00});
      default:  mem_addr_o = addr_q;
    endcase
  end
  assign mem_wdata_o     = (state_q == ST_MARK) ? '1 : buf_q;
  assign dev_in_ready_o  = (state_q == ST_XFER) && dir_i && !have_q;
  assign dev_out_valid_o = (state_q == ST_XFER) && !dir_i && have_q;
  assign dev_out_data_o  = buf_q;

  assign mhs     = mem_req_o && mem_gnt_i;
  assign dhs_in  = dev_in_valid_i && dev_in_ready_o;
  assign dhs_out = dev_out_valid_o && dev_out_ready_i;
  assign abort   = stop_i && (state_q != ST_IDLE) && !mhs && !dhs_in && !dhs_out;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE; widx_q <= '0; mark_q <= '0;
      tbl_q <= '0; addr_q <= '0; buf_q <= '0; rem_q <= '0;
      eol_q <= 1'b0; have_q <= 1'b0; dev_cnt_q <= '0; mem_cnt_q <= '0;
      done_o <= 1'b0; err_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      if (start_i) begin
        state_q <= ST_FETCH; tbl_q <= tbl_i; widx_q <= '0; mark_q <= '0;
        have_q <= 1'b0; dev_cnt_q <= '0; mem_cnt_q <= '0;
      end else if (abort) begin
        state_q <= ST_IDLE;
      end else if (mhs && mem_err_i) begin
        state_q <= ST_IDLE;
        err_o   <= 1'b1;
      end else begin
        case (state_q)
          ST_FETCH: if (mhs) begin
            widx_q <= widx_q + 2'd1;
            if (widx_q == 2'd1) addr_q <= sw;
            if (widx_q == 2'd3) begin
              tbl_q <= tbl_q + 32'd16;
              eol_q <= sw[31];
              rem_q <= len_w;
              if (len_w == '0) state_q <= sw[31] ? ST_MARK : ST_FETCH;
              else             state_q <= ST_XFER;
            end
          end
          ST_XFER: if (dir_i) begin
            if (dhs_in) begin
              buf_q <= dev_in_data_i; have_q <= 1'b1;
              dev_cnt_q <= dev_cnt_q + CNT_W'(step);
            end
            if (mhs) begin
              mem_cnt_q <= mem_cnt_q + CNT_W'(step);
              addr_q <= addr_q + 32'd4; rem_q <= rem_q - LEN_W'(step); have_q <= 1'b0;
              if (seg_last) state_q <= next_seg;
            end
          end else begin
            if (mhs) begin
              buf_q <= mem_rdata_i; have_q <= 1'b1;
              mem_cnt_q <= mem_cnt_q + CNT_W'(step);
            end
            if (dhs_out) begin
              dev_cnt_q <= dev_cnt_q + CNT_W'(step);
              addr_q <= addr_q + 32'd4; rem_q <= rem_q - LEN_W'(step); have_q <= 1'b0;
              if (seg_last) state_q <= next_seg;
            end
          end
          ST_MARK: if (mhs) begin
            mark_q <= mark_q + 1'b1;
            if (mark_q == MW_W'(MARK_WORDS - 1)) begin
              state_q <= ST_IDLE;
              done_o  <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign active_o   = (state_q != ST_IDLE);
  assign cur_addr_o = addr_q;
  assign dev_cnt_o  = dev_cnt_q;
  assign mem_cnt_o  = mem_cnt_q;

  assert_req_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i && !stop_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_wdata_o) && $stable(mem_we_o)));
  assert_dev_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_out_valid_o && !dev_out_ready_i && !stop_i) |=>
      (dev_out_valid_o && $stable(dev_out_data_o)));
  assert_stop_halts_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && active_o && !mhs && !dhs_in && !dhs_out) |=> !active_o);
  assert_start_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (state_q == ST_IDLE));
  assert_cnt_order_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> (dir_i ? (mem_cnt_q <= dev_cnt_q) : (dev_cnt_q <= mem_cnt_q)));
  assert_single_event_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, err_o}));
endmodule

// File: rtl/sgdma_top.sv
module sgdma_top #(
  parameter int CNT_W      = 32,
  parameter int LEN_W      = 16,
  parameter int MARK_BYTES = 128
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [3:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic [31:0] mem_addr_o,
  output logic [31:0] mem_wdata_o,
  input  logic        mem_gnt_i,
  input  logic        mem_err_i,
  input  logic [31:0] mem_rdata_i,
  input  logic        dev_in_valid_i,
  input  logic [31:0] dev_in_data_i,
  output logic        dev_in_ready_o,
  output logic        dev_out_valid_o,
  output logic [31:0] dev_out_data_o,
  input  logic        dev_out_ready_i,
  output logic        irq_o
);
  logic             start, stop, dir, active, done, err;
  logic [31:0]      tbl, done_addr, cur_addr;
  logic [CNT_W-1:0] dev_cnt, mem_cnt;

  sgdma_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .start_o(start), .stop_o(stop),
    .dir_o(dir), .tbl_o(tbl), .done_addr_o(done_addr), .active_i(active),
    .done_i(done), .err_i(err), .cur_addr_i(cur_addr), .dev_cnt_i(dev_cnt),
    .mem_cnt_i(mem_cnt), .irq_o(irq_o)
  );

  sgdma_seq #(.CNT_W(CNT_W), .LEN_W(LEN_W), .MARK_BYTES(MARK_BYTES)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .stop_i(stop), .dir_i(dir),
    .tbl_i(tbl), .done_addr_i(done_addr), .active_o(active), .done_o(done),
    .err_o(err), .cur_addr_o(cur_addr), .dev_cnt_o(dev_cnt), .mem_cnt_o(mem_cnt),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_gnt_i(mem_gnt_i), .mem_err_i(mem_err_i),
    .mem_rdata_i(mem_rdata_i), .dev_in_valid_i(dev_in_valid_i),
    .dev_in_data_i(dev_in_data_i), .dev_in_ready_o(dev_in_ready_o),
    .dev_out_valid_o(dev_out_valid_o), .dev_out_data_o(dev_out_data_o),
    .dev_out_ready_i(dev_out_ready_i)
  );
endmodule

// File: tb/sim_sgdma_top.sv
module sim_sgdma_top;
  import sgdma_pkg::*;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [3:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic        mem_gnt_i = 1'b0, mem_err_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic        dev_in_valid_i = 1'b0;
  logic [31:0] dev_in_data_i = '0;
  logic        dev_in_ready_o, dev_out_valid_o;
  logic [31:0] dev_out_data_o;
  logic        dev_out_ready_i = 1'b0;
  logic        irq_o;

  always #5 clk = ~clk;

  sgdma_top u0 (.*, .clk_i(clk));

  logic [31:0] mem [0:4095];
  bit          src_en = 0, snk_en = 0, err_en = 0;
  logic [31:0] err_addr = '0;
  int          src_idx = 0, snk_idx = 0, snk_bad = 0;
  int          checks = 0, fails = 0;
  localparam logic [31:0] MARK_AD = 32'h3000;
  localparam int          MARK_W  = 32'h3000 / 4;

  function automatic logic [31:0] pat(input int k);
    return (32'(k) * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  // memory, device source and device sink, all decided between edges
  always @(negedge clk) begin
    mem_gnt_i = 1'b0; mem_err_i = 1'b0;
    if (mem_req_o && ($urandom % 4 != 0)) begin
      mem_gnt_i   = 1'b1;
      mem_rdata_i = mem[mem_addr_o[13:2]];
      if (err_en && mem_addr_o == err_addr) mem_err_i = 1'b1;
      else if (mem_we_o) mem[mem_addr_o[13:2]] = mem_wdata_o;
    end
    dev_in_valid_i = src_en && ($urandom % 3 != 0);
    dev_in_data_i  = pat(src_idx);
    if (dev_in_valid_i && dev_in_ready_o) src_idx++;
    dev_out_ready_i = snk_en && ($urandom % 3 != 0);
    if (dev_out_ready_i && dev_out_valid_o) begin
      if (dev_out_data_o != pat(snk_idx)) snk_bad++;
      snk_idx++;
    end
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic wait_status(output logic [31:0] v);
    v = '0;
    for (int i = 0; i < 20000 && v == 0; i++) reg_read(RI_IRQ_ST, v);
  endtask

  task automatic clear_area();
    for (int w = 1024; w < 4096; w++) mem[w] = '0;
  endtask

  task automatic put_desc(input int i, input logic [31:0] ad, input int len, input bit last);
    mem[i*4+0] = 32'hDEADBEEF;
    mem[i*4+1] = swap32(ad);
    mem[i*4+2] = 32'hDEADBEEF;
    mem[i*4+3] = swap32({last, 15'h7FFF, 16'(len)});
  endtask

  task automatic run_xfer(input int nd, input bit dir, input bit zmid, input bit mask_irq);
    int lens [8];
    logic [31:0] bases [8];
    logic [31:0] v, baddr;
    int total, wk, tw, bad, words;
    total = 0; wk = 0; tw = 0; baddr = 32'h1000;
    clear_area();
    src_idx = 0; snk_idx = 0; snk_bad = 0;
    for (int i = 0; i < nd; i++) begin
      lens[i] = (zmid && i == 1) ? 0 : 1 + int'($urandom % 40);
      bases[i] = baddr;
      put_desc(i, baddr, lens[i], i == nd - 1);
      words = (lens[i] + 3) / 4;
      if (!dir) for (int j = 0; j < words; j++) mem[baddr[13:2] + j] = pat(wk + j);
      wk += words; tw += words; total += lens[i];
      baddr += 32'(words * 4 + 8);
    end
    src_en = dir; snk_en = !dir;
    reg_write(RI_IRQ_EN, mask_irq ? 32'd0 : 32'd3);
    reg_write(RI_TBL_LO, 32'h0);
    reg_write(RI_DONE_AD, MARK_AD);
    reg_write(RI_CTRL, dir ? 32'h5 : 32'h1);
    wait_status(v);
    chk(v == 1, "R5 done status after completion area", v, 1);
    #1 chk(irq_o == !mask_irq, "R10 irq line follows enable", 32'(irq_o), 32'(!mask_irq));
    reg_read(RI_CTRL, v);
    chk(v[4:3] == 2'b00, "R5 idle and no fault after completion", v, {29'd0, dir, 2'b00});
    reg_read(RI_DEV_CNT, v);
    chk(v == 32'(total), "R6 R4 device byte count", v, 32'(total));
    reg_read(RI_MEM_CNT, v);
    chk(v == 32'(total), "R6 R4 memory byte count", v, 32'(total));
    bad = 0;
    for (int j = 0; j < 32; j++) if (mem[MARK_W + j] != '1) bad++;
    chk(bad == 0, "R5 completion area all ones", 32'(bad), 0);
    chk(mem[MARK_W + 32] == 0, "R5 nothing written past completion area", mem[MARK_W + 32], 0);
    if (dir) begin
      bad = 0; wk = 0;
      for (int i = 0; i < nd; i++) begin
        words = (lens[i] + 3) / 4;
        for (int j = 0; j < words; j++) begin
          if (mem[bases[i][13:2] + j] != pat(wk)) bad++;
          wk++;
        end
      end
      chk(bad == 0, "R3 R2 R11 device to memory data", 32'(bad), 0);
    end else begin
      chk(snk_bad == 0 && snk_idx == tw, "R3 R2 R11 memory to device data",
          32'(snk_idx), 32'(tw));
    end
    reg_write(RI_IRQ_ST, 32'h1);
    reg_read(RI_IRQ_ST, v);
    chk(v == 0, "R10 write-one clears done status", v, 0);
    src_en = 0; snk_en = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    void'($urandom(32'd2024));
    for (int w = 0; w < 4096; w++) mem[w] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    reg_read(RI_CTRL, v);    chk(v == 0, "R1 control after reset", v, 0);
    reg_read(RI_DEV_CNT, v); chk(v == 0, "R1 device count after reset", v, 0);
    reg_read(RI_MEM_CNT, v); chk(v == 0, "R1 memory count after reset", v, 0);
    reg_read(RI_IRQ_ST, v);  chk(v == 0, "R1 irq status after reset", v, 0);
    chk(!irq_o && !mem_req_o && !dev_out_valid_o && !dev_in_ready_o,
        "R1 outputs idle after reset", {28'd0, irq_o, mem_req_o, dev_out_valid_o, dev_in_ready_o}, 0);
    reg_write(RI_TIMING, 32'hA5C3_0F1E);
    reg_read(RI_TIMING, v); chk(v == 32'hA5C3_0F1E, "R2 timing scratch", v, 32'hA5C3_0F1E);
    reg_read(RI_CUR_HI, v); chk(v == 0, "R2 upper address reads zero", v, 0);

    // directed corner cases
    run_xfer(1, 1'b1, 1'b0, 1'b0);
    run_xfer(3, 1'b1, 1'b1, 1'b0);
    run_xfer(3, 1'b0, 1'b1, 1'b1);
    run_xfer(2, 1'b0, 1'b0, 1'b0);
    // random mix
    for (int r = 0; r < 10; r++) run_xfer(1 + int'($urandom % 6), 1'($urandom % 2), 1'b0, 1'b0);

    // stop while stalled on the device side
    clear_area();
    put_desc(0, 32'h1000, 40, 1'b1);
    snk_en = 0; src_en = 0;
    reg_write(RI_IRQ_EN, 32'd3);
    reg_write(RI_CTRL, 32'h1);
    v = '0;
    for (int i = 0; i < 2000 && v != 4; i++) reg_read(RI_MEM_CNT, v);
    chk(v == 4, "R6 one word read before stall", v, 4);
    reg_write(RI_CTRL, 32'h5);
    reg_read(RI_CTRL, v);
    chk(v[3] == 1'b1 && v[2] == 1'b0, "R9 start while busy ignored", v, 32'h8);
    reg_write(RI_CTRL, 32'h2);
    reg_read(RI_CTRL, v);
    chk(v[1] == 1'b1, "R7 stop bit pending", v, 32'h2);
    repeat (4) @(negedge clk);
    reg_read(RI_CTRL, v);
    chk(v[1] == 1'b0 && v[3] == 1'b0, "R7 stop bit self clears and busy drops", v, 0);
    reg_read(RI_DEV_CNT, v); chk(v == 0, "R6 device count kept after stop", v, 0);
    reg_read(RI_MEM_CNT, v); chk(v == 4, "R6 memory count kept after stop", v, 4);
    reg_read(RI_IRQ_ST, v);  chk(v == 0, "R7 no done status after stop", v, 0);
    chk(mem[MARK_W] == 0, "R7 no completion area after stop", mem[MARK_W], 0);

    // memory error on second data write
    clear_area();
    put_desc(0, 32'h1000, 16, 1'b0);
    put_desc(1, 32'h1100, 8, 1'b1);
    src_idx = 0; src_en = 1; err_en = 1; err_addr = 32'h1004;
    reg_write(RI_CTRL, 32'h5);
    wait_status(v);
    chk(v == 2, "R8 fault status", v, 2);
    #1 chk(irq_o == 1'b1, "R10 irq on fault", 32'(irq_o), 1);
    reg_read(RI_CTRL, v);
    chk(v[4] == 1'b1 && v[3] == 1'b0, "R8 fault set and busy cleared", v, 32'h14);
    reg_read(RI_MEM_CNT, v); chk(v == 4, "R8 R6 memory count at fault", v, 4);
    reg_read(RI_DEV_CNT, v); chk(v == 8, "R8 R6 device count at fault", v, 8);
    chk(mem[MARK_W] == 0, "R8 completion area skipped", mem[MARK_W], 0);
    src_en = 0; err_en = 0;
    reg_write(RI_CTRL, 32'h2);
    repeat (3) @(negedge clk);
    reg_read(RI_CTRL, v);
    chk(v[4] == 1'b0 && v[1] == 1'b0, "R8 stop clears fault", v, 32'h4);
    reg_write(RI_IRQ_ST, 32'h2);
    reg_read(RI_IRQ_ST, v); chk(v == 0, "R10 write-one clears fault status", v, 0);
    #1 chk(irq_o == 1'b0, "R10 irq low after clear", 32'(irq_o), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule